// File: doc/BRIEF.md
# Fixed-OR Sum-of-Products Array with Output Feedback

This block is a soft model of a small programmable sum-of-products device. Ten dedicated input pins and six feedback signals form sixteen literal sources. Each source reaches an AND plane in true and in complement form. Every one of the eight outputs owns eight product terms. Seven of those terms are ORed into the output, and the output drives the complement of that OR. The eighth term is the output's drive enable. No product term is shared between outputs.

The fuse pattern is loaded serially, one bit per clock, while `cfg_load` is high. While loading, every output reports itself as not driving. Outputs 0 to 5 feed back into the AND array. An enabled output feeds back its own driven level. A disabled output feeds back the level an outside agent puts on that pin, which arrives on `pin_ext`. This lets a disabled output serve as an extra input, and it lets an enabled one serve as a helper term for two-pass logic. The array is combinational apart from the fuse register. It is evaluated in a fixed number of unrolled passes, so a feedback chain through all six feedback outputs settles without a combinational loop.

Top module: `pal_array`

## Requirements
- R1: After reset every fuse bit is 1, so every term holds both polarities of input 0 and is false: `out_en` is 0 and `out_val` is all ones.
- R2: While `cfg_load` is high, one `cfg_bit` enters per clock. Once 2048 bits have been sent, stream bit n sets fuse (n mod 32) of term ((n/32) mod 8) of output n/256. Terms 0 to 6 are sum terms and term 7 is the enable term.
- R3: Within a term, fuse 2k selects the true form of source k and fuse 2k+1 selects its complement. Sources 0 to 9 are `in_pins[0..9]`, and sources 10 to 15 are the feedback of outputs 0 to 5. A term is the AND of its selected literals, and a term with no fuse set is true.
- R4: `out_val[o]` is the inverse of the OR of output o's seven sum terms, whether or not the output is enabled.
- R5: With `cfg_load` low, `out_en[o]` equals output o's enable term.
- R6: While `cfg_load` is high, `out_en` is all zeros.
- R7: The feedback of an enabled output 0 to 5 equals its `out_val` bit.
- R8: The feedback of a disabled output i (0 to 5) equals `pin_ext[i]`.
- R9: Any loop-free feedback arrangement settles, including a chain running through all six feedback outputs into a seventh output.
- R10: With `cfg_load` low, the fuse pattern does not change, whatever `cfg_bit` and the input pins do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the fuse register |
| rst | input | 1 | Synchronous active-high reset, sets all fuses to 1 |
| cfg_load | input | 1 | High while the fuse stream is shifted in |
| cfg_bit | input | 1 | Serial fuse data |
| in_pins | input | 10 | Dedicated input pins |
| pin_ext | input | 6 | Outside level on the pins of outputs 0 to 5 |
| out_val | output | 8 | Active-low output levels |
| out_en | output | 8 | Per-output drive enable |

## Verification
The bench attacks the ordering of the fuse stream. A design that reversed literal polarity or swapped terms would disagree with the independent model on almost every random vector. A chain from input 0 through outputs 0 to 6 catches a design with too few evaluation passes, because the last output in the chain would stay stale. A disabled feedback output driven from `pin_ext` catches feedback taken from the undriven internal value. Mid-stream enable checks and toggling of `cfg_bit` between loads catch outputs that drive during loading and a shift register that never stops.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int unsigned PAL_IN       = 10;
    localparam int unsigned PAL_OUT      = 8;
    localparam int unsigned PAL_FB       = 6;
    localparam int unsigned PAL_SUM      = 7;
    localparam int unsigned PAL_SRC      = PAL_IN + PAL_FB;
    localparam int unsigned PAL_LIT      = 2 * PAL_SRC;
    localparam int unsigned PAL_TERMS    = PAL_SUM + 1;
    localparam int unsigned PAL_CFG_BITS = PAL_OUT * PAL_TERMS * PAL_LIT;
    localparam int unsigned PAL_PASSES   = PAL_FB + 1;
endpackage

// File: rtl/pal_cfg_chain.sv
module pal_cfg_chain #(
    parameter int unsigned W = pal_pkg::PAL_CFG_BITS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] fuse_q
);
    typedef struct packed {
        logic [W-1:0] fuse;
    } chain_t;

    chain_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (shift_en) begin
            st_d.fuse = {bit_in, st_q.fuse[W-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.fuse <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign fuse_q = st_q.fuse;

    // R2: a shifting cycle places the serial bit at the top of the chain
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> fuse_q[W-1] == $past(bit_in));

    // R10: with loading off the fuse pattern is frozen
    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !shift_en |=> $stable(fuse_q));

    // R1: leaving reset the fuse pattern is blank (all ones)
    p_blank_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (&fuse_q));
endmodule

// File: rtl/pal_term.sv
module pal_term #(
    parameter int unsigned N_SRC = pal_pkg::PAL_SRC
) (
    input  logic [2*N_SRC-1:0] fuse,
    input  logic [N_SRC-1:0]   src,
    output logic               hit
);
    logic [2*N_SRC-1:0] lit;

    always_comb begin
        for (int k = 0; k < N_SRC; k++) begin
            lit[2*k]   = src[k];
            lit[2*k+1] = ~src[k];
        end
        hit = &(lit | ~fuse);
    end
endmodule

// File: rtl/pal_eval_pass.sv
module pal_eval_pass #(
    parameter int unsigned N_IN  = pal_pkg::PAL_IN,
    parameter int unsigned N_OUT = pal_pkg::PAL_OUT,
    parameter int unsigned N_FB  = pal_pkg::PAL_FB,
    parameter int unsigned N_SUM = pal_pkg::PAL_SUM
) (
    input  logic [N_OUT*(N_SUM+1)*2*(N_IN+N_FB)-1:0] fuse,
    input  logic [N_IN-1:0]                           in_pins,
    input  logic [N_FB-1:0]                           fb,
    input  logic                                      busy,
    output logic [N_OUT-1:0]                          val,
    output logic [N_OUT-1:0]                          en
);
    localparam int unsigned N_SRC   = N_IN + N_FB;
    localparam int unsigned N_LIT   = 2 * N_SRC;
    localparam int unsigned N_TERMS = N_SUM + 1;

    logic [N_SRC-1:0]         src;
    logic [N_OUT*N_TERMS-1:0] hits;

    assign src = {fb, in_pins};

    for (genvar o = 0; o < N_OUT; o++) begin : g_out
        for (genvar t = 0; t < N_TERMS; t++) begin : g_term
            pal_term #(.N_SRC(N_SRC)) u_term (
                .fuse (fuse[(o*N_TERMS+t)*N_LIT +: N_LIT]),
                .src  (src),
                .hit  (hits[o*N_TERMS+t])
            );
        end
    end

    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            val[o] = ~(|hits[o*N_TERMS +: N_SUM]);
            en[o]  = hits[o*N_TERMS+N_SUM] & ~busy;
        end
    end
endmodule

// File: rtl/pal_array.sv
module pal_array #(
    parameter int unsigned N_IN  = pal_pkg::PAL_IN,
    parameter int unsigned N_OUT = pal_pkg::PAL_OUT,
    parameter int unsigned N_FB  = pal_pkg::PAL_FB,
    parameter int unsigned N_SUM = pal_pkg::PAL_SUM
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_load,
    input  logic             cfg_bit,
    input  logic [N_IN-1:0]  in_pins,
    input  logic [N_FB-1:0]  pin_ext,
    output logic [N_OUT-1:0] out_val,
    output logic [N_OUT-1:0] out_en
);
    localparam int unsigned N_LIT  = 2 * (N_IN + N_FB);
    localparam int unsigned CFG_W  = N_OUT * (N_SUM + 1) * N_LIT;
    localparam int unsigned N_PASS = N_FB + 1;

    logic [CFG_W-1:0]                fuse_q;
    logic [N_PASS-1:0][N_OUT-1:0]    val_p;
    logic [N_PASS-1:0][N_OUT-1:0]    en_p;
    logic [N_PASS-1:0][N_FB-1:0]     fb_p;

    pal_cfg_chain #(.W(CFG_W)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .shift_en (cfg_load),
        .bit_in   (cfg_bit),
        .fuse_q   (fuse_q)
    );

    for (genvar p = 0; p < N_PASS; p++) begin : g_pass
        if (p == 0) begin : g_first
            assign fb_p[p] = pin_ext;
        end else begin : g_next
            assign fb_p[p] = (en_p[p-1][N_FB-1:0] & val_p[p-1][N_FB-1:0])
                           | (~en_p[p-1][N_FB-1:0] & pin_ext);
        end
        pal_eval_pass #(
            .N_IN (N_IN), .N_OUT(N_OUT), .N_FB(N_FB), .N_SUM(N_SUM)
        ) u_pass (
            .fuse    (fuse_q),
            .in_pins (in_pins),
            .fb      (fb_p[p]),
            .busy    (cfg_load),
            .val     (val_p[p]),
            .en      (en_p[p])
        );
    end

    assign out_val = val_p[N_PASS-1];
    assign out_en  = en_p[N_PASS-1];

    // R6: nothing drives while the fuse stream is loading
    p_quiet_load_r6: assert property (@(posedge clk) disable iff (rst)
        cfg_load |-> (out_en == '0));

    // R7: an enabled feedback output returns its own level
    p_fb_driven_r7: assert property (@(posedge clk) disable iff (rst)
        ((fb_p[N_PASS-1] ^ out_val[N_FB-1:0]) & out_en[N_FB-1:0]) == '0);

    // R8: a released feedback output returns the outside pin level
    p_fb_released_r8: assert property (@(posedge clk) disable iff (rst)
        ((fb_p[N_PASS-1] ^ pin_ext) & ~out_en[N_FB-1:0]) == '0);
endmodule

// File: tb/pal_array_test.sv
module pal_array_test;
    localparam int CFG = 2048;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_load = 1'b0;
    logic       cfg_bit = 1'b0;
    logic [9:0] in_pins = '0;
    logic [5:0] pin_ext = '0;
    logic [7:0] out_val;
    logic [7:0] out_en;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    pal_array uut (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_bit(cfg_bit),
        .in_pins(in_pins), .pin_ext(pin_ext), .out_val(out_val), .out_en(out_en)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic int fidx(int o, int t, int bitpos);
        return (o*8 + t)*32 + bitpos;
    endfunction

    // independent settling model of the requirements
    function automatic void model(input logic [CFG-1:0] c, input logic [9:0] inp,
                                  input logic [5:0] pin,
                                  output logic [7:0] v, output logic [7:0] e);
        logic [7:0] nv, ne;
        logic [15:0] s;
        v = '1; e = '0;
        for (int it = 0; it < 10; it++) begin
            for (int i = 0; i < 6; i++) s[10+i] = e[i] ? v[i] : pin[i];
            s[9:0] = inp;
            for (int o = 0; o < 8; o++) begin
                logic sop;
                sop = 1'b0;
                for (int t = 0; t < 8; t++) begin
                    logic h;
                    h = 1'b1;
                    for (int k = 0; k < 16; k++) begin
                        if (c[fidx(o,t,2*k)] && !s[k]) h = 1'b0;
                        if (c[fidx(o,t,2*k+1)] && s[k]) h = 1'b0;
                    end
                    if (t < 7) sop = sop | h;
                    else ne[o] = h;
                end
                nv[o] = ~sop;
            end
            v = nv; e = ne;
        end
    endfunction

    function automatic logic [CFG-1:0] rand_cfg();
        logic [CFG-1:0] c;
        c = '1;
        for (int o = 0; o < 8; o++) begin
            int lim;
            lim = 10 + ((o < 6) ? o : 6);
            for (int t = 0; t < 8; t++) begin
                int n;
                c[fidx(o,t,0) +: 32] = '0;
                n = $urandom % 4;
                if (t < 7) begin
                    if (n == 0) begin
                        c[fidx(o,t,0)] = 1'b1;
                        c[fidx(o,t,1)] = 1'b1;
                    end else begin
                        for (int j = 0; j < n; j++)
                            c[fidx(o,t,2*($urandom % lim) + ($urandom % 2))] = 1'b1;
                    end
                end else if (n == 0) begin
                    c[fidx(o,t,2*($urandom % lim) + ($urandom % 2))] = 1'b1;
                end
            end
        end
        return c;
    endfunction

    task automatic load(input logic [CFG-1:0] c);
        @(negedge clk);
        cfg_load = 1'b1;
        for (int i = 0; i < CFG; i++) begin
            cfg_bit = c[i];
            if (i == CFG/2) begin
                #1 check("R6 enables during load", {8'h0, out_en}, 16'h0);
            end
            @(negedge clk);
        end
        cfg_load = 1'b0;
    endtask

    task automatic apply_check(input logic [CFG-1:0] c, input logic [9:0] inp,
                               input logic [5:0] pin, input string req);
        logic [7:0] ev, ee;
        @(negedge clk);
        in_pins = inp; pin_ext = pin; cfg_bit = $urandom % 2;
        #1;
        model(c, inp, pin, ev, ee);
        check({req, " out_val"}, {8'h0, out_val}, {8'h0, ev});
        check({req, " out_en"},  {8'h0, out_en},  {8'h0, ee});
    endtask

    initial begin
        logic [CFG-1:0] c;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset out_en", {8'h0, out_en}, 16'h0);
        check("R1 reset out_val", {8'h0, out_val}, 16'h00ff);

        // chain through all six feedback outputs (R9), enable term (R5)
        c = '1;
        c[fidx(0,0,0) +: 32] = '0; c[fidx(0,0,0)] = 1'b1; c[fidx(0,0,2)] = 1'b1;
        c[fidx(0,7,0) +: 32] = '0;
        for (int i = 1; i < 7; i++) begin
            c[fidx(i,0,0) +: 32] = '0; c[fidx(i,0,2*(10+i-1))] = 1'b1;
            c[fidx(i,7,0) +: 32] = '0;
        end
        c[fidx(7,0,0) +: 32] = '0; c[fidx(7,0,19)] = 1'b1;
        c[fidx(7,7,0) +: 32] = '0; c[fidx(7,7,16)] = 1'b1;
        load(c);
        @(negedge clk); in_pins = 10'b0000000011; pin_ext = '0; #1;
        check("R9 chain val", {8'h0, out_val}, 16'h002a);
        check("R5 enable term val", {8'h0, out_en}, 16'h007f);
        @(negedge clk); in_pins = 10'b1100000000; #1;
        check("R9 chain val flipped", {8'h0, out_val}, 16'h00d5);
        check("R5 enable term on", {8'h0, out_en}, 16'h00ff);

        // released feedback and empty sum term (R8, R3, R4)
        c = '1;
        c[fidx(2,0,0) +: 32] = '0; c[fidx(2,0,6)] = 1'b1;
        c[fidx(2,7,0) +: 32] = '0; c[fidx(2,7,18)] = 1'b1;
        c[fidx(3,0,0) +: 32] = '0; c[fidx(3,0,24)] = 1'b1;
        c[fidx(3,7,0) +: 32] = '0;
        c[fidx(7,0,0) +: 32] = '0;
        c[fidx(7,7,0) +: 32] = '0;
        load(c);
        @(negedge clk); in_pins = 10'b0000001000; pin_ext = 6'b000100; #1;
        check("R8 released fb high", {8'h0, out_val}, 16'h0073);
        check("R5 released enables", {8'h0, out_en}, 16'h0088);
        @(negedge clk); pin_ext = 6'b000000; #1;
        check("R8 released fb low", {15'h0, out_val[3]}, 16'h1);
        @(negedge clk); in_pins = 10'b1000001000; pin_ext = 6'b000100; #1;
        check("R7 driven fb ignores pin", {15'h0, out_val[3]}, 16'h1);
        check("R3 empty term true", {15'h0, out_val[7]}, 16'h0);

        // random loop-free configurations (R2, R3, R4, R5, R7, R9, R10)
        for (int k = 0; k < 6; k++) begin
            c = rand_cfg();
            load(c);
            for (int v = 0; v < 40; v++)
                apply_check(c, 10'($urandom), 6'($urandom), "R2 R4 R10 random");
        end

        done = 1;
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #600000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule